// File: doc/BRIEF.md
# Receive Descriptor Ring Index Manager

This block is the device-side bookkeeping for one receive descriptor ring that lives in host memory. The host posts free descriptors by moving a write index forward, always in steps of eight. The device side consumes them one at a time as receive buffers fill: each `buf_done` pulse moves a fill index forward by one. The ring is full when the fill index equals the write index, so it never holds more than size−1 filled entries. At the end of each frame the block writes the fill index to a status location, and it can raise a host interrupt at the same time. If buffers stay filled but unreported for too long, a timer forces that status write.

A single configuration word sets the rest: the ring size (a power of two), the buffer size that the data mover is told about, the interrupt target, the flush timeout and the channel mode. The channel mode runs the channel, stops it at once, or lets the open frame finish and then stops. The idle output shows when the channel accepts no more events. Descriptor fetching and the data transfer itself belong to neighbouring blocks.

Top module: `rxr_ring_ctl`

## Requirements
- R1: After reset the fill index is 0, the write index is 0 (so `has_room` is 0), `chan_idle` is 1, and `stat_we`, `host_irq` and `align_err` are all 0.
- R2: Configuration bits 23:20 hold the ring exponent N, clamped to the range 5..12. `ring_mask` equals 2^N−1, and the fill index wraps to 0 after entry 2^N−1.
- R3: A write to the host write index keeps only the bits below 2^N and forces the low 3 bits to zero.
- R4: `has_room` is 1 exactly when the fill index differs from the write index. A `buf_done` that arrives while `has_room` is 0 leaves the fill index unchanged.
- R5: A `buf_done` accepted with room advances the fill index by one (modulo the ring size), and the new value shows from the next cycle.
- R6: A write-index value whose low 3 bits are not all zero sets `align_err`. The flag then stays set until reset.
- R7: An accepted `frame_end` gives a one-cycle `stat_we` in the next cycle. `stat_idx` then equals the fill index including any advance made in the same cycle. `stat_idx` holds its value between status writes.
- R8: Configuration bits 31:30 set the channel mode: 10 runs the channel. With 00 or 11 the channel is idle from the next cycle, ignores `buf_done` and `frame_end`, and drops any open frame.
- R9: In mode 01 the channel keeps accepting events only while a frame is open, meaning a buffer has been filled and no `frame_end` has come since. It goes idle after that frame's `frame_end`, and goes idle at once if no frame is open.
- R10: `host_irq` pulses with `stat_we`, and only when configuration bits 13:12 equal 01.
- R11: Configuration bits 11:4 hold a timeout T. If T is not 0 and buffers have been filled without a status write, a status write follows T×`TICKS_PER_UNIT` cycles after the first unreported fill. T=0 turns this off.
- R12: Configuration bits 17:16 select the buffer size on `buf_kbytes`: 00→4, 01→8, 10→12, 11→16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |
| widx_we | input | 1 | Host write-index update strobe |
| widx_wdata | input | 12 | New host write index |
| buf_done | input | 1 | One receive buffer has been filled |
| frame_end | input | 1 | The current frame has ended |
| fill_idx | output | 12 | Next descriptor to fill |
| has_room | output | 1 | At least one posted descriptor is free |
| stat_we | output | 1 | Status write strobe |
| stat_idx | output | 12 | Fill index carried by the status write |
| host_irq | output | 1 | Host interrupt pulse |
| chan_idle | output | 1 | Channel accepts no events |
| align_err | output | 1 | Sticky flag for a misaligned write index |
| ring_mask | output | 12 | Index mask for the configured ring size |
| buf_kbytes | output | 5 | Configured buffer size in KiB |

## Verification
The fill path runs under several patterns. Frames span a single buffer or several. The ring fills up to the write index, which shows the full rule and that a dropped `buf_done` has no effect. The write index wraps and so does the fill index, and a run of short rings is compared against the largest ring, which exposes mask mistakes. Misaligned and oversize write indices separate the rounding from the sticky flag. The mode-01 runs, with a frame open and with none, tell a clean drain apart from a stop at once. A timer run with a slow tick catches off-by-one errors in the flush delay and in the interrupt gating.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the receive ring index manager: configuration
// word layout and channel mode encoding.
package rxr_pkg;
    localparam int CFG_W     = 32;
    localparam int MODE_LSB  = 30;
    localparam int EXP_LSB   = 20;
    localparam int BSZ_LSB   = 16;
    localparam int DEST_LSB  = 12;
    localparam int TMO_LSB   = 4;
    localparam int TMO_W     = 8;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_EOF = 2'b01,
        MODE_RUN = 2'b10,
        MODE_RSV = 2'b11
    } chan_mode_e;

    typedef struct packed {
        chan_mode_e       mode;
        logic [3:0]       exp;
        logic [1:0]       bsz;
        logic [1:0]       dest;
        logic [TMO_W-1:0] tmo;
    } cfg_t;
endpackage

// File: rtl/rxr_cfg.sv
`timescale 1ns/1ps
// rxr_cfg: holds the configuration word and decodes it.
// Assumes: EXP_MIN <= EXP_MAX <= IDX_W. Reserved bits are not stored.
module rxr_cfg
    import rxr_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int EXP_MIN = 5,
    parameter int EXP_MAX = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output chan_mode_e       mode,
    output logic [IDX_W-1:0] ring_mask,
    output logic [4:0]       buf_kbytes,
    output logic             to_host,
    output logic [TMO_W-1:0] tmo
);
    cfg_t       cfg_q;
    logic [3:0] exp_eff;
    logic       unused_rsvd;

    assign unused_rsvd = ^{cfg_wdata[29:24], cfg_wdata[19:18],
                           cfg_wdata[15:14], cfg_wdata[3:0]};

    // Capture the decoded fields on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.mode <= chan_mode_e'(cfg_wdata[MODE_LSB +: 2]);
            cfg_q.exp  <= cfg_wdata[EXP_LSB +: 4];
            cfg_q.bsz  <= cfg_wdata[BSZ_LSB +: 2];
            cfg_q.dest <= cfg_wdata[DEST_LSB +: 2];
            cfg_q.tmo  <= cfg_wdata[TMO_LSB +: TMO_W];
        end
    end

    // Clamp the ring exponent into the legal range.
    always_comb begin
        if (cfg_q.exp < 4'(EXP_MIN))      exp_eff = 4'(EXP_MIN);
        else if (cfg_q.exp > 4'(EXP_MAX)) exp_eff = 4'(EXP_MAX);
        else                              exp_eff = cfg_q.exp;
    end

    // One mask bit per index bit: set below the ring exponent.
    for (genvar b = 0; b < IDX_W; b++) begin : g_mask
        assign ring_mask[b] = (b < int'(exp_eff));
    end

    assign mode       = cfg_q.mode;
    assign buf_kbytes = {({1'b0, cfg_q.bsz} + 3'd1), 2'b00};
    assign to_host    = (cfg_q.dest == 2'b01);
    assign tmo        = cfg_q.tmo;
endmodule

// File: rtl/rxr_idx.sv
`timescale 1ns/1ps
// rxr_idx: host write index and device fill index with the full rule.
// Assumes: ring_mask is 2^N-1. The host posts in steps of 2^STEP_LOG.
module rxr_idx #(
    parameter int IDX_W    = 12,
    parameter int STEP_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ring_mask,
    input  logic             widx_we,
    input  logic [IDX_W-1:0] widx_wdata,
    input  logic             adv_req,
    output logic [IDX_W-1:0] fill_idx,
    output logic [IDX_W-1:0] fill_next,
    output logic             has_room,
    output logic             fill_adv,
    output logic             align_err
);
    localparam logic [IDX_W-1:0] STEP_MASK = IDX_W'((1 << STEP_LOG) - 1);

    logic [IDX_W-1:0] wr_q;
    logic [IDX_W-1:0] fill_q;
    logic             err_q;

    assign has_room  = ((fill_q & ring_mask) != (wr_q & ring_mask));
    assign fill_adv  = adv_req & has_room;
    assign fill_next = fill_adv ? ((fill_q + 1'b1) & ring_mask) : fill_q;

    // Store the rounded, masked host write index and flag misalignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            err_q <= 1'b0;
        end else if (widx_we) begin
            wr_q <= widx_wdata & ring_mask & ~STEP_MASK;
            if ((widx_wdata & STEP_MASK) != '0) err_q <= 1'b1;
        end
    end

    // Advance the fill index on each accepted filled buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_next;
    end

    assign fill_idx  = fill_q;
    assign align_err = err_q;

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !has_room |=> $stable(fill_idx));
    assert_align_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (widx_we && (widx_wdata & STEP_MASK) != '0) |=> align_err);
    assert_align_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);
endmodule

// File: rtl/rxr_chan.sv
`timescale 1ns/1ps
// rxr_chan: channel mode handling and open-frame tracking.
// Assumes: mode comes from registered configuration. The reserved mode counts as off.
module rxr_chan
    import rxr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_mode_e mode,
    input  logic       frame_end,
    input  logic       fill_adv,
    output logic       accept,
    output logic       eof_acc,
    output logic       chan_idle
);
    logic in_frame_q;

    assign accept    = (mode == MODE_RUN) || ((mode == MODE_EOF) && in_frame_q);
    assign eof_acc   = accept & frame_end;
    assign chan_idle = ~accept;

    // Track whether a frame has buffers filled but no end seen yet.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     in_frame_q <= 1'b0;
        else if ((mode == MODE_OFF) || (mode == MODE_RSV)) in_frame_q <= 1'b0;
        else if (eof_acc)                               in_frame_q <= 1'b0;
        else if (fill_adv)                              in_frame_q <= 1'b1;
    end

    assert_stay_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_idle && mode != MODE_RUN) |=> (chan_idle || mode == MODE_RUN));
endmodule

// File: rtl/rxr_notify.sv
`timescale 1ns/1ps
// rxr_notify: status writes on frame end or flush timeout, plus the interrupt.
// Assumes: tmo is in units of TICKS_PER_UNIT cycles. A zero tmo turns the timer off.
module rxr_notify
    import rxr_pkg::*;
#(
    parameter int IDX_W          = 12,
    parameter int TICKS_PER_UNIT = 6400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof_acc,
    input  logic             fill_adv,
    input  logic [IDX_W-1:0] fill_next,
    input  logic [TMO_W-1:0] tmo,
    input  logic             to_host,
    output logic             stat_we,
    output logic [IDX_W-1:0] stat_idx,
    output logic             host_irq
);
    localparam int TICK_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_UNIT - 1);

    logic              pend_q;
    logic [TICK_W-1:0] tick_q;
    logic [TMO_W-1:0]  unit_q;
    logic              fire;
    logic              send;

    assign fire = pend_q && (tmo != '0) && (tick_q == TICK_LAST) &&
                  (unit_q == tmo - 1'b1);
    assign send = eof_acc | fire;

    // Remember filled buffers that no status write has reported yet.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (send)     pend_q <= 1'b0;
        else if (fill_adv) pend_q <= 1'b1;
    end

    // Count ticks and units while a report is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || send || !pend_q) begin
            tick_q <= '0;
            unit_q <= '0;
        end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            unit_q <= unit_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    // Issue the status write and the optional interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_we  <= 1'b0;
            host_irq <= 1'b0;
            stat_idx <= '0;
        end else begin
            stat_we  <= send;
            host_irq <= send & to_host;
            if (send) stat_idx <= fill_next;
        end
    end

    assert_irq_with_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> stat_we);
endmodule

// File: rtl/rxr_ring_ctl.sv
`timescale 1ns/1ps
// rxr_ring_ctl: top of the receive descriptor ring index manager.
// Assumes: a single ring. Events arrive at most one per cycle per input.
module rxr_ring_ctl
    import rxr_pkg::*;
#(
    parameter int IDX_W          = 12,
    parameter int EXP_MIN        = 5,
    parameter int EXP_MAX        = 12,
    parameter int STEP_LOG       = 3,
    parameter int TICKS_PER_UNIT = 6400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             widx_we,
    input  logic [IDX_W-1:0] widx_wdata,
    input  logic             buf_done,
    input  logic             frame_end,
    output logic [IDX_W-1:0] fill_idx,
    output logic             has_room,
    output logic             stat_we,
    output logic [IDX_W-1:0] stat_idx,
    output logic             host_irq,
    output logic             chan_idle,
    output logic             align_err,
    output logic [IDX_W-1:0] ring_mask,
    output logic [4:0]       buf_kbytes
);
    chan_mode_e       mode;
    logic             to_host;
    logic [TMO_W-1:0] tmo;
    logic             accept;
    logic             eof_acc;
    logic             fill_adv;
    logic [IDX_W-1:0] fill_next;

    rxr_cfg #(.IDX_W(IDX_W), .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mode(mode), .ring_mask(ring_mask), .buf_kbytes(buf_kbytes),
        .to_host(to_host), .tmo(tmo)
    );

    rxr_chan u_chan (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frame_end(frame_end),
        .fill_adv(fill_adv), .accept(accept), .eof_acc(eof_acc),
        .chan_idle(chan_idle)
    );

    rxr_idx #(.IDX_W(IDX_W), .STEP_LOG(STEP_LOG)) u_idx (
        .clk(clk), .rst_n(rst_n), .ring_mask(ring_mask),
        .widx_we(widx_we), .widx_wdata(widx_wdata),
        .adv_req(accept & buf_done), .fill_idx(fill_idx),
        .fill_next(fill_next), .has_room(has_room), .fill_adv(fill_adv),
        .align_err(align_err)
    );

    rxr_notify #(.IDX_W(IDX_W), .TICKS_PER_UNIT(TICKS_PER_UNIT)) u_notify (
        .clk(clk), .rst_n(rst_n), .eof_acc(eof_acc), .fill_adv(fill_adv),
        .fill_next(fill_next), .tmo(tmo), .to_host(to_host),
        .stat_we(stat_we), .stat_idx(stat_idx), .host_irq(host_irq)
    );

    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_idle |=> $stable(fill_idx));
endmodule

// File: tb/rxr_ring_ctl_test.sv
`timescale 1ns/1ps
// Bench: a behavioural model with integer state, compared on every cycle,
// plus directed checks at the boundary cases.
module rxr_ring_ctl_test;
    localparam int TPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        widx_we = 1'b0;
    logic [11:0] widx_wdata = '0;
    logic        buf_done = 1'b0;
    logic        frame_end = 1'b0;
    logic [11:0] fill_idx, stat_idx, ring_mask;
    logic        has_room, stat_we, host_irq, chan_idle, align_err;
    logic [4:0]  buf_kbytes;

    int total = 0;
    int bad = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    rxr_ring_ctl #(.TICKS_PER_UNIT(TPU)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .widx_we(widx_we), .widx_wdata(widx_wdata), .buf_done(buf_done),
        .frame_end(frame_end), .fill_idx(fill_idx), .has_room(has_room),
        .stat_we(stat_we), .stat_idx(stat_idx), .host_irq(host_irq),
        .chan_idle(chan_idle), .align_err(align_err), .ring_mask(ring_mask),
        .buf_kbytes(buf_kbytes)
    );

    always #2.5 clk = ~clk;

    // Model state
    int m_cfg = 0, m_wr = 0, m_fill = 0, m_inf = 0, m_pend = 0, m_cnt = 0;
    int m_err = 0, m_stat = 0, m_sidx = 0, m_irq = 0;

    function automatic int f_mask(int cfg);
        int e = (cfg >> 20) & 15;
        if (e < 5) e = 5;
        if (e > 12) e = 12;
        return (1 << e) - 1;
    endfunction

    function automatic int f_accept(int cfg, int inf);
        int md = (cfg >> 30) & 3;
        return (md == 2 || (md == 1 && inf != 0)) ? 1 : 0;
    endfunction

    function automatic int mk(int md, int e, int bs, int dst, int to);
        return (md << 30) | (e << 20) | (bs << 16) | (dst << 12) | (to << 4);
    endfunction

    // Reference model: advance on each rising edge
    always @(posedge clk) begin : model
        int mask, acc, room, adv, eofa, to, fire, snd, fnew, md;
        if (!rst_n) begin
            m_cfg = 0; m_wr = 0; m_fill = 0; m_inf = 0; m_pend = 0; m_cnt = 0;
            m_err = 0; m_stat = 0; m_sidx = 0; m_irq = 0;
        end else begin
            mask = f_mask(m_cfg);
            md   = (m_cfg >> 30) & 3;
            acc  = f_accept(m_cfg, m_inf);
            room = ((m_fill & mask) != (m_wr & mask)) ? 1 : 0;
            adv  = (acc != 0 && buf_done && room != 0) ? 1 : 0;
            fnew = adv ? ((m_fill + 1) & mask) : m_fill;
            eofa = (acc != 0 && frame_end) ? 1 : 0;
            to   = (m_cfg >> 4) & 255;
            fire = (m_pend != 0 && to != 0 && m_cnt == to * TPU - 1) ? 1 : 0;
            snd  = (eofa != 0 || fire != 0) ? 1 : 0;
            m_stat = snd;
            m_irq  = (snd != 0 && ((m_cfg >> 12) & 3) == 1) ? 1 : 0;
            if (snd != 0) m_sidx = fnew;
            m_cnt  = (snd != 0 || m_pend == 0) ? 0 : m_cnt + 1;
            m_pend = (snd != 0) ? 0 : (adv != 0 ? 1 : m_pend);
            if (md == 0 || md == 3) m_inf = 0;
            else if (eofa != 0)     m_inf = 0;
            else if (adv != 0)      m_inf = 1;
            m_fill = fnew;
            if (widx_we) begin
                m_wr = int'(widx_wdata) & mask & ~7;
                if ((int'(widx_wdata) & 7) != 0) m_err = 1;
            end
            if (cfg_we) m_cfg = int'(cfg_wdata);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (run_cmp) begin
            chk("R5 fill_idx", int'(fill_idx), m_fill);
            chk("R4 has_room", int'(has_room),
                ((m_fill & f_mask(m_cfg)) != (m_wr & f_mask(m_cfg))) ? 1 : 0);
            chk("R7 stat_we", int'(stat_we), m_stat);
            chk("R7 stat_idx", int'(stat_idx), m_sidx);
            chk("R10 host_irq", int'(host_irq), m_irq);
            chk("R8 chan_idle", int'(chan_idle), 1 - f_accept(m_cfg, m_inf));
            chk("R6 align_err", int'(align_err), m_err);
            chk("R2 ring_mask", int'(ring_mask), f_mask(m_cfg));
            chk("R12 buf_kbytes", int'(buf_kbytes), 4 * (((m_cfg >> 16) & 3) + 1));
        end
    end

    task automatic step(input logic bd, input logic fe);
        buf_done = bd; frame_end = fe;
        @(negedge clk);
        buf_done = 1'b0; frame_end = 1'b0;
    endtask

    task automatic wcfg(input int d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wwr(input int d);
        widx_we = 1'b1; widx_wdata = 12'(d);
        @(negedge clk);
        widx_we = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin : stim
        int keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_cmp = 1'b1;
        // R1 reset state
        chk("R1 fill_idx", int'(fill_idx), 0);
        chk("R1 chan_idle", int'(chan_idle), 1);
        chk("R1 has_room", int'(has_room), 0);
        chk("R1 align_err", int'(align_err), 0);
        chk("R1 stat_we", int'(stat_we), 0);

        // Run mode, 32 entries, 8K buffers, interrupt to host
        wcfg(mk(2, 5, 1, 1, 0));
        chk("R12 8K", int'(buf_kbytes), 8);
        chk("R2 mask32", int'(ring_mask), 31);
        wwr(8);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R7 stat_we", int'(stat_we), 1);
        chk("R7 stat_idx", int'(stat_idx), 8);
        chk("R10 irq", int'(host_irq), 1);
        chk("R4 full", int'(has_room), 0);
        step(1'b1, 1'b0);
        chk("R4 dropped", int'(fill_idx), 8);

        // Misaligned and oversize write indices
        wwr(13);
        chk("R6 flag", int'(align_err), 1);
        chk("R3 rounded", int'(has_room), 0);
        wwr(12'h3F0);
        chk("R3 masked", int'(has_room), 1);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R4 full16", int'(has_room), 0);
        wwr(0);
        for (int i = 0; i < 16; i++) step(1'b1, i == 15);
        chk("R2 wrap", int'(fill_idx), 0);
        chk("R6 sticky", int'(align_err), 1);

        // Exponent clamping and buffer sizes
        wcfg(mk(2, 3, 0, 1, 0));
        chk("R2 clamp low", int'(ring_mask), 31);
        wcfg(mk(2, 15, 0, 1, 0));
        chk("R2 clamp high", int'(ring_mask), 4095);
        for (int b = 0; b < 4; b++) begin
            wcfg(mk(2, 8, b, 1, 0));
            chk("R12 size", int'(buf_kbytes), 4 * (b + 1));
        end
        wwr(64);

        // Pause at end of frame with a frame open
        step(1'b1, 1'b0);
        wcfg(mk(1, 8, 0, 1, 0));
        chk("R9 drains", int'(chan_idle), 0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R9 idle after eof", int'(chan_idle), 1);
        keep = int'(fill_idx);
        step(1'b1, 1'b1);
        chk("R9 ignored", int'(fill_idx), keep);
        chk("R9 no status", int'(stat_we), 0);
        wcfg(mk(2, 8, 0, 1, 0));
        wcfg(mk(1, 8, 0, 1, 0));
        chk("R9 idle no frame", int'(chan_idle), 1);

        // Stop at once
        wcfg(mk(2, 8, 0, 1, 0));
        step(1'b1, 1'b0);
        wcfg(mk(0, 8, 0, 1, 0));
        chk("R8 off idle", int'(chan_idle), 1);
        keep = int'(fill_idx);
        step(1'b1, 1'b1);
        chk("R8 ignored", int'(fill_idx), keep);
        chk("R8 no status", int'(stat_we), 0);
        wcfg(mk(3, 8, 0, 1, 0));
        chk("R8 rsv idle", int'(chan_idle), 1);

        // Flush timeout, no interrupt target
        wcfg(mk(2, 8, 0, 0, 3));
        repeat (20) @(negedge clk);
        step(1'b1, 1'b0);
        repeat (11) @(negedge clk);
        chk("R11 early", int'(stat_we), 0);
        @(negedge clk);
        chk("R11 fired", int'(stat_we), 1);
        chk("R10 no irq", int'(host_irq), 0);
        repeat (20) @(negedge clk);
        wcfg(mk(2, 8, 0, 1, 0));
        step(1'b1, 1'b0);
        repeat (40) @(negedge clk);
        chk("R11 disabled", int'(stat_we), 0);
        step(1'b0, 1'b1);
        chk("R7 late eof", int'(stat_we), 1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule